// File: doc/BRIEF.md
# Exception Vector Checksum Validator

This block decides whether a user program image may be started. Once the boot-time overlay no longer hides the start of user flash, a start pulse launches a sequencer. It fetches the eight 32-bit exception vector words at byte addresses 0x00 to 0x1C through a plain request/valid read port and accumulates them with 32-bit wraparound. One reserved slot, the word at 0x14, carries a balancing value, so an intact image sums to exactly zero.

When the last word has been added, a one-cycle completion pulse is raised. At the same time exactly one of two verdict outputs goes high. One allows the boot code to branch to the user reset vector at address 0. The other keeps execution in boot mode. The verdict stays until the next accepted start. A start pulse that arrives during a scan is dropped.

Word width, word count, address width, byte or word addressing, and the structure of the zero detector are parameters.

Top module: `vecsum_check`

## Requirements
- R1: After reset, rd_req, done, image_ok and image_bad are all 0.
- R2: A scan requests the words one at a time at byte addresses 0x00, 0x04, 0x08 and so on up to 0x1C, in increasing order. rd_req stays high with a stable rd_addr until rd_valid is seen. A word counts as read in the cycle where rd_req and rd_valid are both 1.
- R3: The sum is taken modulo 2^32. Carries out of bit 31 are discarded.
- R4: The image is judged good (image_ok=1, image_bad=0) only when the sum of the eight words is zero. Otherwise it is judged bad (image_ok=0, image_bad=1).
- R5: done is high for exactly one cycle: the cycle after the eighth word is accepted. The verdict outputs are valid in that same cycle.
- R6: The verdict outputs hold their value until the next accepted start. In the cycle after that start, both are 0. Every scan begins from a zero sum.
- R7: A start pulse during a scan has no effect. The address sequence, the result and the number of done pulses are unchanged.
- R8: rd_valid while no request is outstanding is ignored. It raises no done and leaves the verdict and the next scan's sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a scan when the block is idle |
| rd_data | input | 32 | Read data from flash |
| rd_valid | input | 1 | rd_data is valid for the current request |
| rd_addr | output | 8 | Byte address of the requested word |
| rd_req | output | 1 | Read request outstanding |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| image_ok | output | 1 | Sum was zero; user reset vector may be entered |
| image_bad | output | 1 | Sum was non-zero; stay in boot mode |

## Verification
Five kinds of image are used:
- An all-zero image, the trivial good case.
- A balanced image of large values, where only a wrapping sum gives zero. This separates the modulo-2^32 rule from a wider or saturating adder.
- An image of all-ones words balanced by a small word, so the sum crosses 2^32 several times.
- A sweep over every slot with a single flipped bit, which must always be judged bad. This catches a slot that is skipped or read twice.
- A sweep of off-by-small deltas on the balancing word, which separates an exact zero test from a near-zero one.

Each image runs with read latencies of zero to three cycles. Some runs add start pulses during the scan or stray rd_valid pulses while idle. These show that neither disturbs the address order, the sum or the single done pulse. A clean image run right after a bad one shows that the accumulator and verdict are cleared on start.

// File: rtl/vecsum_pkg.sv
package vecsum_pkg;

   typedef enum logic [0:0] {
      VS_IDLE = 1'b0,
      VS_SCAN = 1'b1
   } vs_state_e;

endpackage

// File: rtl/vecsum_seq.sv
module vecsum_seq
   import vecsum_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rd_valid,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             launch,
   output logic             take,
   output logic             last_take
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

   vs_state_e state_q;

   assign busy      = (state_q == VS_SCAN);
   assign launch    = start && (state_q == VS_IDLE);
   assign take      = busy && rd_valid;
   assign last_take = take && (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VS_IDLE;
         idx     <= '0;
      end else if (launch) begin
         state_q <= VS_SCAN;
         idx     <= '0;
      end else if (take) begin
         if (last_take) begin
            state_q <= VS_IDLE;
            idx     <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R7: start while scanning leaves position and state alone
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rd_valid) |=> (busy && $stable(idx)));

   // R2: the word index never runs past the last vector
   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(idx) < NUM_WORDS));

   // R2: the index advances by exactly one per accepted word
   p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !last_take) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/vecsum_accum.sv
module vecsum_accum #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] sum_now
);

   logic [DATA_W-1:0] acc_q;

   // R3: DATA_W-bit add, carry out of the top bit dropped
   assign sum_now = acc_q + data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (take) begin
         acc_q <= sum_now;
      end
   end

   // R8: without an accepted word or a fresh start the running sum is frozen
   p_acc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clear) |=> $stable(acc_q));

   // R6: a new scan begins from zero
   p_acc_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0));

endmodule

// File: rtl/vecsum_verdict.sv
module vecsum_verdict #(
   parameter int DATA_W    = 32,
   parameter bit ZERO_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              last_take,
   input  logic [DATA_W-1:0] sum_now,
   output logic              done,
   output logic              image_ok,
   output logic              image_bad
);

   localparam int NCHUNK = DATA_W / 8;

   logic is_zero;

   generate
      if (ZERO_TREE) begin : g_tree
         logic [NCHUNK-1:0] chunk_nz;
         for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
            assign chunk_nz[c] = |sum_now[c*8 +: 8];
         end
         assign is_zero = ~|chunk_nz;
      end else begin : g_flat
         assign is_zero = (sum_now == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         image_ok  <= 1'b0;
         image_bad <= 1'b0;
      end else begin
         done <= last_take;
         if (launch) begin
            image_ok  <= 1'b0;
            image_bad <= 1'b0;
         end else if (last_take) begin
            image_ok  <= is_zero;
            image_bad <= !is_zero;
         end
      end
   end

   // R5: completion is a single-cycle pulse
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: exactly one verdict is presented with done
   p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({image_ok, image_bad}) == 1));

   // R4: the two verdicts are never raised together
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({image_ok, image_bad}));

   // R6: the verdict only moves on a start or a completion
   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> ($stable({image_ok, image_bad}) || done));

endmodule

// File: rtl/vecsum_check.sv
module vecsum_check #(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 8,
   parameter int ADDR_W    = 8,
   parameter bit BYTE_ADDR = 1'b1,
   parameter bit ZERO_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_req,
   output logic              done,
   output logic              image_ok,
   output logic              image_bad
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int ADDR_SHIFT = BYTE_ADDR ? $clog2(WORD_BYTES) : 0;
   localparam int SPAN       = NUM_WORDS << ADDR_SHIFT;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("vecsum_check: DATA_W must be a positive multiple of 8");
      end
      if (NUM_WORDS < 2) begin : g_bad_count
         $error("vecsum_check: NUM_WORDS must be at least 2");
      end
      if (SPAN > (1 << ADDR_W)) begin : g_bad_addr
         $error("vecsum_check: ADDR_W too narrow for the vector table");
      end
   endgenerate

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic             launch;
   logic             take;
   logic             last_take;
   logic [DATA_W-1:0] sum_now;

   vecsum_seq #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_valid  (rd_valid),
      .busy      (busy),
      .idx       (idx),
      .launch    (launch),
      .take      (take),
      .last_take (last_take)
   );

   vecsum_accum #(
      .DATA_W (DATA_W)
   ) accum_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (launch),
      .take    (take),
      .data    (rd_data),
      .sum_now (sum_now)
   );

   vecsum_verdict #(
      .DATA_W    (DATA_W),
      .ZERO_TREE (ZERO_TREE)
   ) verdict_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .last_take (last_take),
      .sum_now   (sum_now),
      .done      (done),
      .image_ok  (image_ok),
      .image_bad (image_bad)
   );

   assign rd_req = busy;

   generate
      if (BYTE_ADDR) begin : g_byte_addr
         assign rd_addr = ADDR_W'(idx) << ADDR_SHIFT;
      end else begin : g_word_addr
         assign rd_addr = ADDR_W'(idx);
      end
   endgenerate

   // R2: an unanswered request is held with the same address
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   // R2: requests stay inside the vector table
   p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (int'(rd_addr) < SPAN));

   // R5: done follows the final accepted read and ends the scan
   p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req);

endmodule

// File: tb/vecsum_check_tb_top.sv
module vecsum_check_tb_top;

   localparam int NW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] rd_data = '0;
   logic        rd_valid = 1'b0;
   logic [7:0]  rd_addr;
   logic        rd_req;
   logic        done;
   logic        image_ok;
   logic        image_bad;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] mem [NW];

   always #10 clk = ~clk;

   vecsum_check dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .rd_addr   (rd_addr),
      .rd_req    (rd_req),
      .done      (done),
      .image_ok  (image_ok),
      .image_bad (image_bad)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [31:0] mem_sum();
      logic [31:0] s = '0;
      for (int i = 0; i < NW; i++) s = s + mem[i];
      return s;
   endfunction

   // fill the table and set slot 5 (byte 0x14) so the wrapped sum is zero
   task automatic build_balanced(input logic [31:0] seed);
      logic [31:0] s = '0;
      for (int i = 0; i < NW; i++) begin
         mem[i] = (seed * 32'h9E37_79B9) ^ (32'hF000_0000 + i * 32'h1357_9BDF);
         if (i != 5) s = s + mem[i];
      end
      mem[5] = -s;
   endtask

   // one complete scan; the bench drives at falling edges only
   task automatic run_scan(input int lat, input bit poke, input string tag);
      logic [31:0] exp_sum = mem_sum();
      bit          exp_ok  = (exp_sum == 32'd0);
      int k = 0;
      int w = 0;
      int guard = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R6", {tag, " ok cleared on start"}, {31'd0, image_ok}, 32'd0);
      check("R6", {tag, " bad cleared on start"}, {31'd0, image_bad}, 32'd0);
      while (k < NW && guard < 400) begin
         guard++;
         if (!rd_req) begin
            check("R2", {tag, " request held"}, {31'd0, rd_req}, 32'd1);
            break;
         end
         if (w == lat) begin
            check("R2", {tag, " address order"}, {24'd0, rd_addr}, k * 4);
            rd_valid = 1'b1;
            rd_data  = mem[k];
            k++;
            w = 0;
         end else begin
            rd_valid = 1'b0;
            rd_data  = 32'hDEAD_BEEF ^ k;
            w++;
         end
         start = poke && (k == 3);
         @(negedge clk);
      end
      start    = 1'b0;
      rd_valid = 1'b0;
      check("R7", {tag, " word count"}, k, NW);
      check("R5", {tag, " done after last word"}, {31'd0, done}, 32'd1);
      check("R4", {tag, " image_ok"}, {31'd0, image_ok}, {31'd0, exp_ok});
      check("R4", {tag, " image_bad"}, {31'd0, image_bad}, {31'd0, !exp_ok});
      check("R2", {tag, " request dropped at end"}, {31'd0, rd_req}, 32'd0);
      @(negedge clk);
      check("R5", {tag, " done one cycle"}, {31'd0, done}, 32'd0);
      check("R6", {tag, " verdict held"}, {30'd0, image_ok, image_bad},
            {30'd0, exp_ok, !exp_ok});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : stim
      for (int i = 0; i < NW; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      check("R1", "rd_req in reset", {31'd0, rd_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "rd_req after reset", {31'd0, rd_req}, 32'd0);
      check("R1", "done after reset", {31'd0, done}, 32'd0);
      check("R1", "image_ok after reset", {31'd0, image_ok}, 32'd0);
      check("R1", "image_bad after reset", {31'd0, image_bad}, 32'd0);

      // R4: all-zero image is good
      for (int lat = 0; lat < 4; lat++) run_scan(lat, 1'b0, "zero image R4");

      // R3: large balanced values only cancel with wraparound
      for (int s = 1; s < 5; s++) begin
         build_balanced(s);
         for (int lat = 0; lat < 4; lat++) run_scan(lat, 1'b0, "balanced R3");
      end

      // R3: seven all-ones words balanced by 7, sum crosses 2^32 repeatedly
      for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
      mem[5] = 32'd7;
      run_scan(0, 1'b0, "carry chain R3");
      run_scan(2, 1'b0, "carry chain R3");

      // R4: one flipped bit in any slot must be rejected
      for (int slot = 0; slot < NW; slot++) begin
         build_balanced(32'd11);
         mem[slot] = mem[slot] ^ (32'h1 << (slot * 4));
         run_scan(slot % 4, 1'b0, "flipped slot R4");
      end

      // R4: balancing word off by a small delta
      for (int d = -3; d <= 3; d++) begin
         build_balanced(32'd23);
         mem[5] = mem[5] + d;
         run_scan(1, 1'b0, "delta sweep R4");
      end

      // R7: start pulses during the scan are dropped
      build_balanced(32'd31);
      run_scan(2, 1'b1, "start ignored R7");
      mem[0] = mem[0] + 1;
      run_scan(0, 1'b1, "start ignored bad R7");

      // R8: stray rd_valid while idle after a bad verdict
      rd_data  = 32'h1234_5678;
      rd_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R8", "no done on stray valid", {31'd0, done}, 32'd0);
         check("R8", "no request on stray valid", {31'd0, rd_req}, 32'd0);
         check("R8", "verdict kept", {30'd0, image_ok, image_bad}, 32'd1);
      end
      rd_valid = 1'b0;
      // R6 R8: next good scan must start from a zero sum
      build_balanced(32'd41);
      run_scan(1, 1'b0, "clean after stray R8");

      repeat (2) @(negedge clk);
      summary();
   end

endmodule